// File: doc/BRIEF.md
# Symbol timing control loop

This block closes the feedback path of a phase-locked symbol timing recovery loop for a binary antipodal receiver whose carrier phase is already known. An external interpolator delivers matched-filter samples at about two per symbol. For each sample the loop runs an interpolation-control counter. When the counter wraps, it flags the previous sample as the symbol centre. On those samples only, the loop computes an early-late timing error, a hard bit decision and a new fractional interval for the interpolator.

The counter is a decrementing modulo-1 accumulator, where a full turn equals 2^CW. Its step is one half plus the output of a proportional-plus-integral loop filter, so the loop can speed up or slow down the strobe rate. The fractional interval is taken from the counter at the wrap and held until the next wrap. This keeps it steady across both interpolator outputs of a symbol. All arithmetic is two's-complement fixed point. The filter gains and the shift are parameters chosen for the bandwidth and damping targets.

Top module: `symtime_loop`

## Requirements
- R1: The counter eta resets to 0 and, on every sample with in_valid high, becomes (eta - W) mod 2^CW with W = 2^(CW-1) + v, where v is the held loop output. A sample underflows when eta < W, using eta before the step. With v = 0 from reset, the first valid sample and every second one after it underflow.
- R2: strobe_o is high for exactly the one clock that follows a valid sample that underflowed, and is low in every other cycle.
- R3: On an underflow sample, err_o becomes e = a*(x - s2). Here x is the current sample, s2 is the sample two valid samples back, and a is +1 when the previous sample s1 is non-negative and -1 otherwise. err_o is 0 in every cycle where strobe_o is low.
- R4: On an underflow sample, dec_o becomes 1 if s1 is non-negative and 0 if it is negative. dec_o holds its value otherwise.
- R5: On an underflow sample, mu_o becomes min(2*eta, 2^CW - 1), using eta before the step. mu_o holds its value otherwise.
- R6: On an underflow sample, the loop output becomes v = clamp((K1*e + I) >>> SH, -2^(CW-2), +2^(CW-2)), where I is the integrator before the update, and the integrator then becomes I + K2*e. Both hold on other samples. loop_o shows v, and the new v first affects the counter step of the next valid sample.
- R7: A cycle with in_valid low changes no state: the counter, the sample history, the loop state and all outputs other than strobe_o keep their values.
- R8: After reset, all outputs are 0 and the sample history is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An interpolated sample is present |
| in_sample | input | DW | Interpolated sample, signed |
| strobe_o | output | 1 | Previous valid sample was a symbol centre |
| mu_o | output | CW | Held fractional interval, unsigned fraction of 2^CW |
| dec_o | output | 1 | Bit decision, 1 for a non-negative centre sample |
| err_o | output | DW+2 | Timing error, signed, zero off strobe |
| loop_o | output | CW | Held loop filter output, signed, in counter units |

## Verification
A wrong counter value or step shows at the ports within a few samples. The strobe pattern shifts against the expected one, and the next mu_o that is reported is wrong. A fault in the error sign or the sample history shows on the next strobe as a wrong err_o. From there it spreads into loop_o and, one sample later, into the strobe spacing, so a bad integrator drifts the strobe cadence away for the rest of the run. Hold faults show in the first non-strobe cycle, as a change in mu_o, dec_o or loop_o, or as a non-zero err_o.

// File: rtl/symtime_loop.sv
module symtime_loop #(
  parameter int DW      = 12,
  parameter int CW      = 16,
  parameter int AW      = 28,
  parameter int K1_GAIN = 4,
  parameter int K2_GAIN = 1,
  parameter int GAIN_SH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 strobe_o,
  output logic [CW-1:0]        mu_o,
  output logic                 dec_o,
  output logic signed [DW+1:0] err_o,
  output logic signed [CW-1:0] loop_o
);
  localparam logic [CW-1:0]        HALF   = {1'b1, {(CW-1){1'b0}}};
  localparam logic signed [CW-1:0] VLIM_C = {2'b01, {(CW-2){1'b0}}};
  localparam logic signed [AW-1:0] VLIM_A = AW'(VLIM_C);
  localparam logic signed [AW-1:0] K1S    = AW'(K1_GAIN);
  localparam logic signed [AW-1:0] K2S    = AW'(K2_GAIN);

  logic [CW-1:0]        eta_q;
  logic signed [CW-1:0] v_q;
  logic signed [AW-1:0] integ_q;
  logic signed [DW-1:0] s1_q, s2_q;

  logic [CW-1:0] w;
  logic          uf;
  assign w  = HALF + v_q;
  assign uf = eta_q < w;

  logic signed [DW:0]   diff;
  logic signed [DW+1:0] ted;
  logic signed [AW-1:0] ted_w, sum, vr;
  logic signed [CW-1:0] v_n;
  assign diff  = {in_sample[DW-1], in_sample} - {s2_q[DW-1], s2_q};
  assign ted   = s1_q[DW-1] ? -{diff[DW], diff} : {diff[DW], diff};
  assign ted_w = AW'(ted);
  assign sum   = ted_w * K1S + integ_q;
  assign vr    = sum >>> GAIN_SH;
  assign v_n   = (vr > VLIM_A)  ? VLIM_C :
                 (vr < -VLIM_A) ? -VLIM_C : vr[CW-1:0];

  logic [CW:0]   dbl;
  logic [CW-1:0] mu_n;
  assign dbl  = {eta_q, 1'b0};
  assign mu_n = dbl[CW] ? {CW{1'b1}} : dbl[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eta_q    <= '0;
      v_q      <= '0;
      integ_q  <= '0;
      s1_q     <= '0;
      s2_q     <= '0;
      strobe_o <= 1'b0;
      mu_o     <= '0;
      dec_o    <= 1'b0;
      err_o    <= '0;
    end else begin
      strobe_o <= in_valid && uf;
      err_o    <= (in_valid && uf) ? ted : '0;
      if (in_valid) begin
        eta_q <= eta_q - w;
        s1_q  <= in_sample;
        s2_q  <= s1_q;
        if (uf) begin
          mu_o    <= mu_n;
          dec_o   <= ~s1_q[DW-1];
          v_q     <= v_n;
          integ_q <= integ_q + ted_w * K2S;
        end
      end
    end
  end

  assign loop_o = v_q;
endmodule

module symtime_loop_chk #(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 strobe_o,
  input logic [CW-1:0]        mu_o,
  input logic                 dec_o,
  input logic signed [DW+1:0] err_o,
  input logic signed [CW-1:0] loop_o
);
  localparam logic signed [CW-1:0] VL = {2'b01, {(CW-2){1'b0}}};

  // R2
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $past(in_valid));
  // R3
  ted_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> err_o == '0);
  // R4
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(dec_o));
  // R5
  mu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(mu_o));
  // R6
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(loop_o));
  // R6
  loop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_o <= VL) && (loop_o >= -VL));
endmodule

bind symtime_loop symtime_loop_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .strobe_o(strobe_o),
  .mu_o(mu_o), .dec_o(dec_o), .err_o(err_o), .loop_o(loop_o)
);

// File: tb/sim_symtime_loop.sv
module sim_symtime_loop;
  localparam int DW = 12, CW = 16, AW = 28;
  localparam int K1 = 8, K2 = 1, SH = 1;
  localparam int ONE = 1 << CW, HALF = 1 << (CW - 1), VLIM = 1 << (CW - 2);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic strobe_o, dec_o;
  logic [CW-1:0] mu_o;
  logic signed [DW+1:0] err_o;
  logic signed [CW-1:0] loop_o;

  always #10 clk = ~clk;

  symtime_loop #(.DW(DW), .CW(CW), .AW(AW), .K1_GAIN(K1), .K2_GAIN(K2), .GAIN_SH(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .strobe_o(strobe_o), .mu_o(mu_o), .dec_o(dec_o), .err_o(err_o), .loop_o(loop_o));

  typedef struct { int mu; int dec; int err; int loop; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int m_eta = 0, m_v = 0, m_int = 0, m_s1 = 0, m_s2 = 0;
  int last_mu = 0, last_dec = 0, last_loop = 0;
  bit mon_on = 0, finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input int x);
    int w, e, a, vr;
    exp_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = DW'(x);
    w = HALF + m_v;
    if (m_eta < w) begin
      a  = (m_s1 >= 0) ? 1 : -1;
      e  = a * (x - m_s2);
      vr = (K1 * e + m_int) >>> SH;
      if (vr > VLIM) vr = VLIM;
      if (vr < -VLIM) vr = -VLIM;
      it.mu   = (2 * m_eta > ONE - 1) ? ONE - 1 : 2 * m_eta;
      it.dec  = (m_s1 >= 0) ? 1 : 0;
      it.err  = e;
      it.loop = vr;
      q.push_back(it);
      m_int = m_int + K2 * e;
      m_v   = vr;
    end
    m_eta = m_eta - w;
    if (m_eta < 0) m_eta += ONE;
    m_s2 = m_s1;
    m_s1 = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sample = DW'(777);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'({20'd0, seed[27:16]}) - 2048;
  endfunction

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        if (strobe_o) begin
          if (q.size() == 0) begin
            chk("R2 unexpected strobe", 1, 0);
          end else begin
            it = q.pop_front();
            chk("R1 strobe present", 1, 1);
            chk("R5 mu on strobe", int'(mu_o), it.mu);
            chk("R4 decision", int'(dec_o), it.dec);
            chk("R3 ted error", int'(err_o), it.err);
            chk("R6 loop output", int'(loop_o), it.loop);
            last_mu = it.mu; last_dec = it.dec; last_loop = it.loop;
          end
        end else begin
          chk("R3 ted zero off strobe", int'(err_o), 0);
          chk("R5 R7 mu hold", int'(mu_o), last_mu);
          chk("R4 R7 dec hold", int'(dec_o), last_dec);
          chk("R6 R7 loop hold", int'(loop_o), last_loop);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    int pat[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R8 reset strobe", int'(strobe_o), 0);
    chk("R8 reset mu", int'(mu_o), 0);
    chk("R8 reset dec", int'(dec_o), 0);
    chk("R8 reset err", int'(err_o), 0);
    chk("R8 reset loop", int'(loop_o), 0);
    mon_on = 1;
    idle(3);
    for (int i = 0; i < 40; i++) send(0);
    pat[0] = 2000; pat[1] = 2000; pat[2] = -2000; pat[3] = -2000;
    for (int i = 0; i < 240; i++) send(pat[i % 4]);
    for (int i = 0; i < 120; i++) begin
      send(rnd());
      if (i % 5 == 4) idle(2);
    end
    for (int i = 0; i < 300; i++) send(-1800 + (i * 700) % 3600);
    for (int i = 0; i < 400; i++) send(rnd());
    pat[0] = -2048; pat[1] = 2047; pat[2] = 2047; pat[3] = -2048;
    for (int i = 0; i < 160; i++) send(pat[i % 4]);
    idle(4);
    #1;
    chk("R1 no missing strobes", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule